// File: doc/BRIEF.md
# Clip-Driven Gain Limiter Controller

This block closes the overload loop around a digital volume and bass stage. Each audio sample is marked by a one-cycle strobe. The volume and bass stages raise a clip flag when they overflow. The block answers with an effective 9-bit volume code and a bass-boost enable. While clipping persists, it attenuates one 0.5 dB code at a time at a programmable attack interval. Once clipping has stopped, it walks the gain back up one code at a time at a programmable release interval, and never passes the programmed level.

Both intervals are counted in sample strobes and coded exponentially. An attack code `a` gives 4^a strobes per step, so codes 0 to 7 span 1 to 16384. A release code `r` gives 16·2^r strobes per step, so codes 0 to 15 span 16 to 524288. A policy input decides what a bass clip does. It can be treated like a volume clip, or it can drop the bass boost entirely and restore it after a clip-free hold-off. The reset input is asserted asynchronously and released through an internal two-stage synchroniser.

Top module: `gain_limiter_ctrl`

## Requirements
- R1: While reset is held and for the first two clock edges after `rst_n` rises, `vol_eff` is 0x0FA (-2 dB) and `bass_boost_en` equals `bass_boost_prog`. The first functional update happens on the third edge.
- R2: With `lim_enable` low, `vol_eff` equals the `vol_prog` of the previous clock edge, and `bass_boost_en` equals `bass_boost_prog`.
- R3: With the limiter enabled, every run of 4^`attack_code` consecutive strobes that carry a volume-reducing clip lowers `vol_eff` by exactly one code. The run count restarts on any strobe without such a clip.
- R4: With the limiter enabled, `vol_eff` rises by one code after every run of 16·2^`release_code` consecutive strobes without a volume-reducing clip. No rise happens earlier, and any clip restarts the count.
- R5: With `bass_policy`=1, a bass clip is a volume-reducing clip, and `bass_boost_en` keeps following `bass_boost_prog`.
- R6: With `bass_policy`=0, a strobe carrying a bass clip forces `bass_boost_en` low from the next cycle, and the bass clip does not reduce `vol_eff`.
- R7: With `bass_policy`=0, the boost returns on the edge of the (16·2^`release_code`+1)-th consecutive strobe without a bass clip.
- R8: While enabled and inside its legal range, `vol_eff` changes by at most one code per clock.
- R9: While enabled, `vol_eff` stays at or above 0x040 (soft mute) and at or below the ceiling max(`vol_prog`, 0x040). A value out of range is loaded with the ceiling on the next edge. Code 0x0FE is 0 dB, and each code is 0.5 dB.
- R10: Cycles without `sample_stb` neither advance any interval nor change `vol_eff`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_enable | input | 1 | Limiter on; when low, the programmed volume passes straight through |
| bass_policy | input | 1 | 1: a bass clip cuts volume; 0: a bass clip drops the boost |
| vol_prog | input | 9 | Programmed volume code |
| bass_boost_prog | input | 1 | Programmed bass boost enable |
| attack_code | input | 3 | Attack interval code, 4^code strobes per step |
| release_code | input | 4 | Release interval code, 16·2^code strobes per step |
| sample_stb | input | 1 | One strobe per word-clock sample |
| vol_clip | input | 1 | Volume stage overflow flag |
| bass_clip | input | 1 | Bass stage overflow flag |
| vol_eff | output | 9 | Effective volume code |
| bass_boost_en | output | 1 | Effective bass boost enable |

## Verification
Two pairs of functions can land on the same edge. First, the range clamp can coincide with an attack or release tick. The bench enables the limiter with a programmed code below the current output while a clip is being strobed, and it expects the clamp to win. Second, in the drop-boost policy, the bass hold-off timer keeps running alongside the volume release timer. The bench holds a bass clip for a few strobes and then counts both timers past their intervals together, so it judges the boost restore edge and the release step in one window. A behavioural model predicts both outputs on every clock.

// File: rtl/lim_pkg.sv
package lim_pkg;
  // Action chosen for the effective volume register on a clock edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DOWN = 2'd1,
    ACT_UP   = 2'd2,
    ACT_LOAD = 2'd3
  } step_act_e;
endpackage

// File: rtl/lim_interval_decode.sv
module lim_interval_decode #(
  parameter int ATT_CODE_W    = 3,
  parameter int REL_CODE_W    = 4,
  parameter int REL_BASE_LOG2 = 4,
  parameter int CNT_W         = 20
) (
  input  logic [ATT_CODE_W-1:0] attack_code,
  input  logic [REL_CODE_W-1:0] release_code,
  output logic [CNT_W-1:0]      att_len,
  output logic [CNT_W-1:0]      rel_len,
  output logic [CNT_W-1:0]      hold_len
);
  localparam int REL_BASE = 1 << REL_BASE_LOG2;

  always_comb begin
    // attack: 4^code strobes per step
    att_len  = CNT_W'(1) << {attack_code, 1'b0};
    // release: base * 2^code strobes per step
    rel_len  = CNT_W'(REL_BASE) << release_code;
    // bass hold-off: strictly longer than one release interval
    hold_len = rel_len + CNT_W'(1);
  end
endmodule

// File: rtl/lim_step_timer.sv
module lim_step_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             hit;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    hit     = (cnt_inc >= len);
    fire    = stb && run && !clr && hit;
    cnt_d   = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (stb) begin
      if (run) cnt_d = hit ? '0 : cnt_inc;
      else     cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else           cnt_q <= cnt_d;
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !clr) |=> (cnt_q == $past(cnt_q)))
    else $error("timer advanced without strobe");
endmodule

// File: rtl/lim_gain_tracker.sv
module lim_gain_tracker
  import lim_pkg::*;
#(
  parameter int           VOL_W      = 9,
  parameter logic [8:0]   MUTE_CODE  = 9'h040,
  parameter logic [8:0]   RESET_CODE = 9'h0FA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             stb,
  input  logic [VOL_W-1:0] vol_prog,
  input  logic             dn_tick,
  input  logic             up_tick,
  output logic [VOL_W-1:0] vol_eff
);
  localparam logic [VOL_W-1:0] MUTE_V  = VOL_W'(MUTE_CODE);
  localparam logic [VOL_W-1:0] RESET_V = VOL_W'(RESET_CODE);

  logic [VOL_W-1:0] eff_q, eff_d, ceil_v, load_v;
  step_act_e        act;
  logic             out_of_range;

  always_comb begin
    ceil_v       = (vol_prog < MUTE_V) ? MUTE_V : vol_prog;
    out_of_range = (eff_q > ceil_v) || (eff_q < MUTE_V);
    load_v       = enable ? ceil_v : vol_prog;
    if (!enable || out_of_range)          act = ACT_LOAD;
    else if (dn_tick && eff_q > MUTE_V)   act = ACT_DOWN;
    else if (up_tick && eff_q < ceil_v)   act = ACT_UP;
    else                                  act = ACT_HOLD;
    unique case (act)
      ACT_LOAD: eff_d = load_v;
      ACT_DOWN: eff_d = eff_q - VOL_W'(1);
      ACT_UP:   eff_d = eff_q + VOL_W'(1);
      default:  eff_d = eff_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_q <= RESET_V;
    else        eff_q <= eff_d;
  end

  assign vol_eff = eff_q;

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (vol_eff == $past(vol_prog)))
    else $error("bypass did not follow programmed code");

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && vol_eff >= MUTE_V && vol_eff <= ceil_v) |=>
      (vol_eff == $past(vol_eff) || vol_eff == $past(vol_eff) + VOL_W'(1) ||
       vol_eff + VOL_W'(1) == $past(vol_eff)))
    else $error("volume jumped more than one code");

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (vol_eff >= MUTE_V && vol_eff <= $past(ceil_v)))
    else $error("volume outside legal range");

  // R10
  no_strobe_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !stb && !out_of_range) |=> $stable(vol_eff))
    else $error("volume moved without strobe");
endmodule

// File: rtl/lim_bass_guard.sv
module lim_bass_guard #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             stb,
  input  logic             bass_clip,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             boost_prog,
  output logic             boost_en
);
  logic kill_q, kill_d, restore;

  lim_step_timer #(.CNT_W(CNT_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!active),
    .stb  (stb),
    .run  (kill_q && !bass_clip),
    .len  (hold_len),
    .fire (restore)
  );

  always_comb begin
    kill_d = kill_q;
    if (!active)                kill_d = 1'b0;
    else if (stb && bass_clip)  kill_d = 1'b1;
    else if (restore)           kill_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kill_q <= 1'b0;
    else        kill_q <= kill_d;
  end

  assign boost_en = boost_prog && !kill_q;

  // R6
  boost_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stb && bass_clip) |=> !boost_en)
    else $error("boost not dropped on bass clip");

  // R5
  boost_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (boost_en == boost_prog))
    else $error("boost altered while guard inactive");
endmodule

// File: rtl/gain_limiter_ctrl.sv
module gain_limiter_ctrl #(
  parameter int         VOL_W         = 9,
  parameter int         ATT_CODE_W    = 3,
  parameter int         REL_CODE_W    = 4,
  parameter int         REL_BASE_LOG2 = 4,
  parameter logic [8:0] MUTE_CODE     = 9'h040,
  parameter logic [8:0] RESET_CODE    = 9'h0FA
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lim_enable,
  input  logic                  bass_policy,
  input  logic [VOL_W-1:0]      vol_prog,
  input  logic                  bass_boost_prog,
  input  logic [ATT_CODE_W-1:0] attack_code,
  input  logic [REL_CODE_W-1:0] release_code,
  input  logic                  sample_stb,
  input  logic                  vol_clip,
  input  logic                  bass_clip,
  output logic [VOL_W-1:0]      vol_eff,
  output logic                  bass_boost_en
);
  localparam int REL_BITS = REL_BASE_LOG2 + (1 << REL_CODE_W);
  localparam int ATT_BITS = 2 * (1 << ATT_CODE_W) - 1;
  localparam int CNT_W    = (REL_BITS > ATT_BITS) ? REL_BITS : ATT_BITS;

  // reset: asynchronous assert, two-stage synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [CNT_W-1:0] att_len, rel_len, hold_len;
  logic             cut_req, att_fire, rel_fire, guard_on;

  assign cut_req  = vol_clip || (bass_policy && bass_clip);
  assign guard_on = lim_enable && !bass_policy;

  lim_interval_decode #(
    .ATT_CODE_W   (ATT_CODE_W),
    .REL_CODE_W   (REL_CODE_W),
    .REL_BASE_LOG2(REL_BASE_LOG2),
    .CNT_W        (CNT_W)
  ) u_dec (
    .attack_code (attack_code),
    .release_code(release_code),
    .att_len     (att_len),
    .rel_len     (rel_len),
    .hold_len    (hold_len)
  );

  lim_step_timer #(.CNT_W(CNT_W)) u_attack (
    .clk  (clk),
    .rst_n(rst_s2),
    .clr  (!lim_enable),
    .stb  (sample_stb),
    .run  (cut_req),
    .len  (att_len),
    .fire (att_fire)
  );

  lim_step_timer #(.CNT_W(CNT_W)) u_release (
    .clk  (clk),
    .rst_n(rst_s2),
    .clr  (!lim_enable),
    .stb  (sample_stb),
    .run  (!cut_req),
    .len  (rel_len),
    .fire (rel_fire)
  );

  lim_gain_tracker #(
    .VOL_W     (VOL_W),
    .MUTE_CODE (MUTE_CODE),
    .RESET_CODE(RESET_CODE)
  ) u_gain (
    .clk     (clk),
    .rst_n   (rst_s2),
    .enable  (lim_enable),
    .stb     (sample_stb),
    .vol_prog(vol_prog),
    .dn_tick (att_fire),
    .up_tick (rel_fire),
    .vol_eff (vol_eff)
  );

  lim_bass_guard #(.CNT_W(CNT_W)) u_bass (
    .clk       (clk),
    .rst_n     (rst_s2),
    .active    (guard_on),
    .stb       (sample_stb),
    .bass_clip (bass_clip),
    .hold_len  (hold_len),
    .boost_prog(bass_boost_prog),
    .boost_en  (bass_boost_en)
  );

  // R3 R4
  tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_s2)
    !(att_fire && rel_fire))
    else $error("attack and release ticked together");
endmodule

// File: tb/tb_gain_limiter_ctrl.sv
module tb_gain_limiter_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lim_enable, bass_policy, bass_boost_prog;
  logic [8:0] vol_prog;
  logic [2:0] attack_code;
  logic [3:0] release_code;
  logic       sample_stb, vol_clip, bass_clip;
  logic [8:0] vol_eff;
  logic       bass_boost_en;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  gain_limiter_ctrl dut (
    .clk(clk), .rst_n(rst_n), .lim_enable(lim_enable), .bass_policy(bass_policy),
    .vol_prog(vol_prog), .bass_boost_prog(bass_boost_prog),
    .attack_code(attack_code), .release_code(release_code),
    .sample_stb(sample_stb), .vol_clip(vol_clip), .bass_clip(bass_clip),
    .vol_eff(vol_eff), .bass_boost_en(bass_boost_en)
  );

  // behavioural reference model
  int m_eff, m_att, m_rel, m_hold, m_age;
  bit m_kill;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_eff = 250; m_att = 0; m_rel = 0; m_hold = 0; m_kill = 0; m_age = 0;
    end else if (m_age < 2) begin
      m_age++;
    end else begin
      int ceil_v, old;
      bit cut, af, rf;
      ceil_v = (vol_prog < 64) ? 64 : int'(vol_prog);
      old = m_eff;
      if (!lim_enable) begin
        m_eff = vol_prog; m_att = 0; m_rel = 0; m_hold = 0; m_kill = 0;
      end else begin
        cut = vol_clip || (bass_policy && bass_clip);
        af = 0; rf = 0;
        if (sample_stb) begin
          if (cut) begin
            m_rel = 0;
            if (m_att + 1 >= (1 << (2 * attack_code))) begin af = 1; m_att = 0; end
            else m_att++;
          end else begin
            m_att = 0;
            if (m_rel + 1 >= (16 << release_code)) begin rf = 1; m_rel = 0; end
            else m_rel++;
          end
        end
        if (old > ceil_v || old < 64) m_eff = ceil_v;
        else if (af && old > 64)      m_eff = old - 1;
        else if (rf && old < ceil_v)  m_eff = old + 1;
        if (bass_policy) begin
          m_kill = 0; m_hold = 0;
        end else if (sample_stb) begin
          if (bass_clip) begin m_kill = 1; m_hold = 0; end
          else if (m_kill) begin
            if (m_hold + 1 >= (16 << release_code) + 1) begin m_kill = 0; m_hold = 0; end
            else m_hold++;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (int'(vol_eff) !== m_eff || bass_boost_en !== (bass_boost_prog && !m_kill)) begin
      errors++;
      $display("FAIL %s model: vol_eff=%h exp %h boost=%b exp %b", tag,
               vol_eff, m_eff[8:0], bass_boost_en, bass_boost_prog && !m_kill);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    int base;
    rst_n = 0; lim_enable = 0; bass_policy = 1; vol_prog = 9'h0FE; bass_boost_prog = 1;
    attack_code = 3'd1; release_code = 4'd0; sample_stb = 1; vol_clip = 0; bass_clip = 0;
    tick(3);
    chk("R1 reset volume", vol_eff, 9'h0FA);
    chk("R1 reset boost", bass_boost_en, 1);
    rst_n = 1;
    tick(2);
    chk("R1 release latency", vol_eff, 9'h0FA);
    tick(1);
    tag = "R2";
    chk("R2 bypass", vol_eff, 9'h0FE);
    vol_prog = 9'h120; tick(1);
    chk("R2 bypass follow", vol_eff, 9'h120);
    tag = "R9";
    lim_enable = 1; vol_prog = 9'h0FE; tick(1);
    chk("R9 clamp to ceiling", vol_eff, 9'h0FE);
    tag = "R3";
    vol_clip = 1; tick(20);
    chk("R3 attack 4 per step", vol_eff, 9'h0F9);
    tag = "R4";
    vol_clip = 0; tick(40);
    chk("R4 release 16 per step", vol_eff, 9'h0FB);
    tick(48);
    chk("R4 release to ceiling", vol_eff, 9'h0FE);
    tick(8);
    chk("R9 no rise past ceiling", vol_eff, 9'h0FE);
    tag = "R5";
    attack_code = 3'd0; bass_clip = 1; tick(10);
    chk("R5 bass clip cuts volume", vol_eff, 9'h0F4);
    chk("R5 boost kept", bass_boost_en, 1);
    tag = "R6";
    bass_policy = 0; tick(5);
    chk("R6 boost dropped", bass_boost_en, 0);
    chk("R6 volume untouched", vol_eff, 9'h0F4);
    tag = "R7";
    bass_clip = 0; tick(16);
    chk("R7 boost still held off", bass_boost_en, 0);
    tick(1);
    chk("R7 boost restored", bass_boost_en, 1);
    chk("R4 release during hold-off", vol_eff, 9'h0F5);
    tag = "R10";
    sample_stb = 0; vol_clip = 1; tick(50);
    chk("R10 no strobe no change", vol_eff, 9'h0F5);
    for (int i = 0; i < 10; i++) begin
      sample_stb = 1; tick(1); sample_stb = 0; tick(1);
    end
    chk("R10 gated strobes", vol_eff, 9'h0EB);
    tag = "R3";
    sample_stb = 1; attack_code = 3'd2; tick(32);
    chk("R3 attack 16 per step", vol_eff, 9'h0E9);
    tag = "R4";
    release_code = 4'd1; vol_clip = 0; base = vol_eff; tick(31);
    chk("R4 no early release", vol_eff, base);
    tick(1);
    chk("R4 release 32 per step", vol_eff, base + 1);
    tag = "R9";
    vol_prog = 9'h048; attack_code = 3'd0; vol_clip = 1; tick(1);
    chk("R9 clamp over clip", vol_eff, 9'h048);
    tick(20);
    chk("R9 soft-mute floor", vol_eff, 9'h040);
    tag = "R8";
    vol_prog = 9'h030; vol_clip = 0; tick(1);
    chk("R9 ceiling floor for low code", vol_eff, 9'h040);
    tag = "R2";
    lim_enable = 0; bass_policy = 0; bass_clip = 1; tick(1);
    chk("R2 bypass low code", vol_eff, 9'h030);
    chk("R2 boost passes through", bass_boost_en, 1);
    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule